// File: doc/BRIEF.md
# TDM Transmit Channel Enable Selector

This block decides, slot by slot, whether a time-division-multiplexed serial transmitter drives the current channel of a frame of up to 128 channels. It keeps a channel counter that a frame-sync pulse clears and a slot strobe advances. The counter is compared against a small control register and eight 16-bit per-channel enable registers, and the block reports the decision for the current slot as a transmit-enable flag and a mask flag.

Channels fall into eight blocks of sixteen. In two-partition operation only two blocks are selectable. The first partition holds an even block and the second holds an odd block, so at most 32 channels can be enabled. In eight-partition operation every block has its own enable register. A 2-bit selection mode turns selection off, drops unselected slots, masks unselected slots, or takes the two partition blocks from the receive-side assignment for symmetric operation. The serializer uses the flags directly. The current block number is also available as a read-only output.

Top module: `tdm_tx_chan_sel`

## Requirements
- R1: After reset, ctrl_rdata is 0, the channel counter and cur_blk are 0, and all eight enable registers hold 0.
- R2: The control register maps its fields as follows: bits [1:0] are the selection mode, bits [3:2] are the partition-A block field, bits [5:4] are the partition-B block field, and bit 6 is the partition-mode bit (1 selects eight partitions). Bits [15:7] always read 0, and writes to them have no effect.
- R3: When fsync is high at a clock edge, the channel becomes 0 at that edge, even if slot_stb is also high. Otherwise slot_stb advances the channel by one, and the channel wraps from 127 to 0.
- R4: cur_blk equals the current channel divided by 16.
- R5: With mode 00, tx_en is 1 and tx_mask is 0 for every channel, whatever the enable registers and block fields hold.
- R6: With a nonzero mode and the partition-mode bit set, channel c is selected when bit c%16 of enable register c/16 is 1. Enable register 0 covers channels 0 to 15 and register 7 covers channels 112 to 127.
- R7: With a nonzero mode other than 11 and the partition-mode bit clear, partition A is block 2*A and partition B is block 2*B+1, where A and B are the two block fields. Channel c in partition A is selected by bit c%16 of enable register 0, and in partition B by bit c%16 of enable register 1. Channels in any other block are never selected.
- R8: With mode 11 and the partition-mode bit clear, the partition blocks are 2*rx_blk_a and 2*rx_blk_b+1. The transmit block fields are not used.
- R9: With mode 01 or 11, tx_en equals the selection and tx_mask is 0. With mode 10, tx_en is 1 and tx_mask is the inverse of the selection.
- R10: A write with en_we high loads en_wdata into the enable register that en_addr selects, numbered 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame-sync pulse; clears the channel counter |
| slot_stb | input | 1 | Advances the channel counter by one slot |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 16 | Control register write data |
| ctrl_rdata | output | 16 | Control register read-back |
| en_we | input | 1 | Enable register write strobe |
| en_addr | input | 3 | Enable register index |
| en_wdata | input | 16 | Enable register write data |
| rx_blk_a | input | 2 | Receive partition-A block field (used in mode 11) |
| rx_blk_b | input | 2 | Receive partition-B block field (used in mode 11) |
| tx_en | output | 1 | Transmitter drives the current slot |
| tx_mask | output | 1 | Current slot is shifted but its output is masked |
| cur_blk | output | 3 | Block of the current channel |

## Verification
The hardest case to reach is the two-partition mapping. A fault there only appears when a particular pair of block fields lines up with a particular channel and enable bit. In mode 11 a fault is hidden whenever the receive and transmit fields happen to agree. The bench therefore sweeps every mode, both partition settings and all sixteen block-field pairs across a complete 128-slot frame. The receive fields are driven to values that always differ from the transmit fields. Each enable register is loaded with a distinct pattern so that a wrong register or a wrong bit changes the result.

// File: rtl/tdm_tx_chan_sel.sv
module tdm_tx_chan_sel #(
  parameter int NCH = 128,
  parameter int BLK = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fsync,
  input  logic        slot_stb,
  input  logic        ctrl_we,
  input  logic [15:0] ctrl_wdata,
  output logic [15:0] ctrl_rdata,
  input  logic        en_we,
  input  logic [2:0]  en_addr,
  input  logic [15:0] en_wdata,
  input  logic [1:0]  rx_blk_a,
  input  logic [1:0]  rx_blk_b,
  output logic        tx_en,
  output logic        tx_mask,
  output logic [2:0]  cur_blk
);
  localparam int CW   = $clog2(NCH);
  localparam int BW   = $clog2(BLK);
  localparam int NBLK = NCH / BLK;

  logic [1:0]    mode_q, fa_q, fb_q;
  logic          part8_q;
  logic [CW-1:0] ch_q;
  logic [BLK-1:0] en_q [NBLK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      fa_q    <= '0;
      fb_q    <= '0;
      part8_q <= 1'b0;
    end else if (ctrl_we) begin
      mode_q  <= ctrl_wdata[1:0];
      fa_q    <= ctrl_wdata[3:2];
      fb_q    <= ctrl_wdata[5:4];
      part8_q <= ctrl_wdata[6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ch_q <= '0;
    else if (fsync)    ch_q <= '0;
    else if (slot_stb) ch_q <= ch_q + 1'b1;
  end

  for (genvar i = 0; i < NBLK; i++) begin : g_en
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             en_q[i] <= '0;
      else if (en_we && en_addr == 3'(i))     en_q[i] <= en_wdata;
    end
  end

  assign ctrl_rdata = {9'd0, part8_q, fb_q, fa_q, mode_q};

  logic [2:0]    blk;
  logic [BW-1:0] idx;
  logic [1:0]    pa, pb;
  logic          hit_a, hit_b, sel;

  assign blk     = ch_q[CW-1:BW];
  assign idx     = ch_q[BW-1:0];
  assign cur_blk = blk;
  assign pa      = (mode_q == 2'b11) ? rx_blk_a : fa_q;
  assign pb      = (mode_q == 2'b11) ? rx_blk_b : fb_q;
  assign hit_a   = (blk == {pa, 1'b0});
  assign hit_b   = (blk == {pb, 1'b1});

  always_comb begin
    if (part8_q)    sel = en_q[blk][idx];
    else if (hit_a) sel = en_q[0][idx];
    else if (hit_b) sel = en_q[1][idx];
    else            sel = 1'b0;
  end

  always_comb begin
    case (mode_q)
      2'b00:   begin tx_en = 1'b1; tx_mask = 1'b0; end
      2'b10:   begin tx_en = 1'b1; tx_mask = ~sel; end
      default: begin tx_en = sel;  tx_mask = 1'b0; end
    endcase
  end
endmodule

module tdm_tx_chan_sel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fsync,
  input logic        slot_stb,
  input logic [15:0] ctrl_rdata,
  input logic        tx_en,
  input logic        tx_mask
  ,input logic [2:0] cur_blk
);
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rdata[15:7] == 9'd0);
  // R3
  fsync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> cur_blk == 3'd0);
  // R3
  hold_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fsync && !slot_stb) |=> $stable(cur_blk));
  // R5
  mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rdata[1:0] == 2'b00) |-> (tx_en && !tx_mask));
  // R9
  mask_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_mask |-> (ctrl_rdata[1:0] == 2'b10 && tx_en));
endmodule

bind tdm_tx_chan_sel tdm_tx_chan_sel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fsync(fsync), .slot_stb(slot_stb),
  .ctrl_rdata(ctrl_rdata), .tx_en(tx_en), .tx_mask(tx_mask), .cur_blk(cur_blk)
);

// File: tb/tdm_tx_chan_sel_tb.sv
module tdm_tx_chan_sel_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fsync = 0, slot_stb = 0, ctrl_we = 0, en_we = 0;
  logic [15:0] ctrl_wdata = 0, en_wdata = 0;
  logic [2:0]  en_addr = 0;
  logic [1:0]  rx_blk_a = 0, rx_blk_b = 0;
  logic [15:0] ctrl_rdata;
  logic        tx_en, tx_mask;
  logic [2:0]  cur_blk;

  int errors = 0, checks = 0;
  logic [15:0] en_m [8];
  logic [1:0]  m_mode, m_a, m_b;
  logic        m_p8;

  always #10 clk = ~clk;

  tdm_tx_chan_sel u_dut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .slot_stb(slot_stb),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
    .en_we(en_we), .en_addr(en_addr), .en_wdata(en_wdata),
    .rx_blk_a(rx_blk_a), .rx_blk_b(rx_blk_b),
    .tx_en(tx_en), .tx_mask(tx_mask), .cur_blk(cur_blk));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [15:0] v);
    @(negedge clk); ctrl_we = 1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 0;
  endtask

  task automatic wr_en(input int i, input logic [15:0] v);
    @(negedge clk); en_we = 1; en_addr = 3'(i); en_wdata = v;
    @(negedge clk); en_we = 0;
    en_m[i] = v;
  endtask

  task automatic pulse(input logic fs, input logic st);
    @(negedge clk); fsync = fs; slot_stb = st;
    @(negedge clk); fsync = 0; slot_stb = 0;
  endtask

  function automatic logic [1:0] ref_flags(input int c);
    int b, pa, pb;
    logic s;
    b = c / 16;
    pa = 2 * ((m_mode == 2'b11) ? int'(rx_blk_a) : int'(m_a));
    pb = 2 * ((m_mode == 2'b11) ? int'(rx_blk_b) : int'(m_b)) + 1;
    if (m_p8)         s = en_m[b][c % 16];
    else if (b == pa) s = en_m[0][c % 16];
    else if (b == pb) s = en_m[1][c % 16];
    else              s = 1'b0;
    case (m_mode)
      2'b00:   return 2'b10;
      2'b10:   return {1'b1, ~s};
      default: return {s, 1'b0};
    endcase
  endfunction

  task automatic run_frame(input string req);
    pulse(1, 0);
    for (int c = 0; c < 128; c++) begin
      if (c != 0) pulse(0, 1);
      chk(req, {tx_en, tx_mask}, ref_flags(c));
      chk("R4", cur_blk, c / 16);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) en_m[i] = 16'h0;
    m_mode = 0; m_a = 0; m_b = 0; m_p8 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1", ctrl_rdata, 16'h0);
    chk("R1", cur_blk, 0);
    chk("R1", {tx_en, tx_mask}, 2'b10);
    wr_ctrl(16'h0041);
    m_mode = 1; m_p8 = 1;
    run_frame("R1 R6");
    // R2 reserved bits
    wr_ctrl(16'hFFFF);
    chk("R2", ctrl_rdata, 16'h007F);
    wr_ctrl(16'h0000);
    chk("R2", ctrl_rdata, 16'h0000);
    // R10 load enables
    for (int i = 0; i < 8; i++)
      wr_en(i, 16'hA5C3 ^ 16'(i * 16'h1357) ^ 16'(1 << i));
    // R3 wrap and fsync priority
    pulse(1, 0);
    for (int c = 1; c < 128; c++) pulse(0, 1);
    chk("R3", cur_blk, 3'd7);
    pulse(0, 1);
    chk("R3", cur_blk, 3'd0);
    for (int c = 0; c < 40; c++) pulse(0, 1);
    chk("R3", cur_blk, 3'd2);
    pulse(1, 1);
    chk("R3", cur_blk, 3'd0);
    // R5 R6 R7 R8 R9 R10 sweep
    for (int md = 0; md < 4; md++)
      for (int p = 0; p < 2; p++)
        for (int a = 0; a < 4; a++)
          for (int b = 0; b < 4; b++) begin
            m_mode = 2'(md); m_p8 = p[0]; m_a = 2'(a); m_b = 2'(b);
            rx_blk_a = 2'(3 - a);
            rx_blk_b = 2'((b + 1) % 4);
            wr_ctrl({9'd0, m_p8, m_b, m_a, m_mode});
            chk("R2", ctrl_rdata, {9'd0, m_p8, m_b, m_a, m_mode});
            if (md == 0)      run_frame("R5");
            else if (p == 1)  run_frame("R6 R9 R10");
            else if (md == 3) run_frame("R8 R9");
            else              run_frame("R7 R9");
          end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule